// File: doc/BRIEF.md
# Byte-Pair Word Framer

This block adapts a byte-wide serial link to a 16-bit word datapath. On the receive side it pairs consecutive incoming bytes into one word. The first byte of each pair becomes bits 7:0 and the second becomes bits 15:8. The finished word is presented for exactly one cycle with a strobe. Pairing depends only on how many bytes have arrived. A resync input forces the next byte to be treated as a low byte again, so a host can recover word alignment.

On the transmit side the block accepts one 16-bit word through a valid/ready handshake. It then offers the word to the byte transmitter as two byte transfers, low byte first. Each transfer waits for the transmitter's ready. A new word is accepted only after the high byte has been handed off.

Top module: `byte_word_framer`

## Requirements
- R1: After reset, rx_word_valid_o and tx_byte_valid_o are 0, tx_word_ready_i is 1, and the receive phase points at the low byte.
- R2: A received byte pair (handshake rx_byte_valid_i) forms rx_word_o = {second byte, first byte}.
- R3: rx_word_valid_o pulses high for exactly one cycle, in the cycle after the second byte of a pair is taken. It is never high two cycles in a row unless a new pair completes.
- R4: Bytes that arrive on back-to-back cycles, including a byte in the same cycle that a word is emitted, are all used: none is dropped and pairing continues.
- R5: A resync_i pulse discards any held low byte, so the next byte received is a low byte. When resync_i and a byte come in the same cycle, that byte is the low byte.
- R6: A transmit word is accepted when tx_word_valid_i and tx_word_ready_o are both 1. Its bytes then appear on tx_byte_o, bits 7:0 first and then bits 15:8, each held stable until tx_byte_ready_i takes it.
- R7: tx_word_ready_o is 0 from acceptance until the cycle the high byte is taken, and tx_byte_valid_o is 0 whenever no byte is pending.
- R8: The transmitter may stall (tx_byte_ready_i low) for any number of cycles without loss or reordering of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| resync_i | input | 1 | Realign receive pairing to the low byte |
| rx_byte_i | input | 8 | Received byte |
| rx_byte_valid_i | input | 1 | Received byte strobe |
| rx_word_o | output | 16 | Assembled word |
| rx_word_valid_o | output | 1 | One-cycle strobe for rx_word_o |
| tx_word_i | input | 16 | Word to transmit |
| tx_word_valid_i | input | 1 | Transmit word offered |
| tx_word_ready_o | output | 1 | Framer can take a word |
| tx_byte_o | output | 8 | Byte offered to the UART transmitter |
| tx_byte_valid_o | output | 1 | Byte offered |
| tx_byte_ready_i | input | 1 | UART transmitter takes the byte |

Note: R1 names the transmit ready signal tx_word_ready_i, but this port is the output tx_word_ready_o; R1 refers to tx_word_ready_o.

## Verification
The hardest receive case is a byte that lands in the same cycle a word is emitted, or in the same cycle as resync_i. The bench sends an unbroken burst of bytes on consecutive cycles, and also a byte together with resync_i, and checks that the pairing stays correct afterwards. On the transmit side the hard case is a transmitter stall in the middle of a word. The bench holds tx_byte_ready_i low for varying stretches between the low and high byte. While the word is in flight it also keeps offering a second word, to show that the second word waits.

// File: rtl/byte_word_framer_pkg.sv
package byte_word_framer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_LO = 2'd1, TX_HI = 2'd2} tx_state_e;
endpackage

// File: rtl/bwf_rx_pack.sv
module bwf_rx_pack
  import byte_word_framer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              resync_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic              phase_q;  // 1: low byte held
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= 1'b0;
      lo_q         <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (byte_valid_i) begin
        if (phase_q && !resync_i) begin
          word_o       <= {byte_i, lo_q};
          word_valid_o <= 1'b1;
          phase_q      <= 1'b0;
        end else begin
          lo_q    <= byte_i;
          phase_q <= 1'b1;
        end
      end else if (resync_i) begin
        phase_q <= 1'b0;
      end
    end
  end

  assert_pulse_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o || $past(byte_valid_i));
  assert_word_needs_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) |-> $past(byte_valid_i));
  assert_resync_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !word_valid_o);
endmodule

// File: rtl/bwf_tx_split.sv
module bwf_tx_split
  import byte_word_framer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i
);
  tx_state_e         st_q;
  logic [WORD_W-1:0] buf_q;

  assign word_ready_o = (st_q == TX_IDLE);
  assign byte_valid_o = (st_q != TX_IDLE);
  assign byte_o       = (st_q == TX_HI) ? buf_q[WORD_W-1:BYTE_W] : buf_q[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      buf_q <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (word_valid_i) begin
          buf_q <= word_i;
          st_q  <= TX_LO;
        end
        TX_LO: if (byte_ready_i) st_q <= TX_HI;
        TX_HI: if (byte_ready_i) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o));
  assert_no_accept_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_ready_o |=> !word_ready_o && byte_valid_o);
  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_ready_o && byte_valid_o));
  assert_lo_then_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && byte_ready_i && $past(word_valid_i && word_ready_o) |=> byte_valid_o);
endmodule

// File: rtl/byte_word_framer.sv
module byte_word_framer
  import byte_word_framer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              resync_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_byte_valid_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_word_valid_o,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tx_word_valid_i,
  output logic              tx_word_ready_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_byte_valid_o,
  input  logic              tx_byte_ready_i
);
  bwf_rx_pack u_rx (
    .clk_i, .rst_ni, .resync_i,
    .byte_i(rx_byte_i), .byte_valid_i(rx_byte_valid_i),
    .word_o(rx_word_o), .word_valid_o(rx_word_valid_o)
  );

  bwf_tx_split u_tx (
    .clk_i, .rst_ni,
    .word_i(tx_word_i), .word_valid_i(tx_word_valid_i), .word_ready_o(tx_word_ready_o),
    .byte_o(tx_byte_o), .byte_valid_o(tx_byte_valid_o), .byte_ready_i(tx_byte_ready_i)
  );

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> tx_word_ready_o && !tx_byte_valid_o);
endmodule

// File: tb/byte_word_framer_test.sv
`timescale 1ns/1ps
module byte_word_framer_test;
  logic clk = 0, rst_ni = 0, resync = 0;
  logic [7:0] rx_b = 0; logic rx_v = 0;
  logic [15:0] rx_w; logic rx_wv;
  logic [15:0] tx_w = 0; logic tx_wv = 0, tx_wr;
  logic [7:0] tx_b; logic tx_bv, tx_br = 0;
  int checks = 0, fails = 0;
  logic [15:0] rx_exp[$];
  logic [7:0]  tx_exp[$];
  logic [7:0]  lo_hold; bit have_lo = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_word_framer uut (
    .clk_i(clk), .rst_ni(rst_ni), .resync_i(resync),
    .rx_byte_i(rx_b), .rx_byte_valid_i(rx_v),
    .rx_word_o(rx_w), .rx_word_valid_o(rx_wv),
    .tx_word_i(tx_w), .tx_word_valid_i(tx_wv), .tx_word_ready_o(tx_wr),
    .tx_byte_o(tx_b), .tx_byte_valid_o(tx_bv), .tx_byte_ready_i(tx_br)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  // receive driver: one byte per cycle, model predicts pairing (R2 R4 R5)
  task automatic rx_byte(input logic [7:0] b, input bit rs = 0);
    rx_b = b; rx_v = 1; resync = rs;
    if (rs) have_lo = 0;
    if (have_lo) begin rx_exp.push_back({b, lo_hold}); have_lo = 0; end
    else begin lo_hold = b; have_lo = 1; end
    @(posedge clk); #1;
    rx_v = 0; resync = 0;
  endtask

  // rx monitor: sampled mid-cycle (R2 R3)
  logic prev_wv = 0;
  always @(negedge clk) if (rst_ni) begin
    if (rx_wv) begin
      if (rx_exp.size() == 0) chk(0, "R3 unexpected word", rx_w, 0);
      else begin
        logic [15:0] e; e = rx_exp.pop_front();
        chk(rx_w == e, "R2 rx word", rx_w, e);
      end
    end
  end

  // tx monitor: byte order and content (R6 R8)
  always @(negedge clk) if (rst_ni) begin
    if (tx_bv && tx_br) begin
      if (tx_exp.size() == 0) chk(0, "R6 unexpected byte", tx_b, 0);
      else begin
        logic [7:0] e; e = tx_exp.pop_front();
        chk(tx_b == e, "R6 tx byte order", tx_b, e);
      end
    end
    chk(!(tx_bv && tx_wr), "R7 ready while busy", tx_wr, 0);
  end

  task automatic tx_send(input logic [15:0] w, input int stall_lo, input int stall_hi);
    tx_w = w; tx_wv = 1;
    while (!tx_wr) begin @(posedge clk); #1; end
    tx_exp.push_back(w[7:0]); tx_exp.push_back(w[15:8]);
    @(posedge clk); #1;
    tx_wv = 1; tx_w = 16'hDEAD;  // keep offering: must wait (R7)
    repeat (stall_lo) begin
      chk(tx_bv && tx_b == w[7:0] && !tx_wr, "R8 stall lo", tx_b, w[7:0]);
      @(posedge clk); #1;
    end
    tx_br = 1; @(posedge clk); #1; tx_br = 0;
    chk(!tx_wr, "R7 busy before hi", tx_wr, 0);
    repeat (stall_hi) begin
      chk(tx_bv && tx_b == w[15:8], "R8 stall hi", tx_b, w[15:8]);
      @(posedge clk); #1;
    end
    tx_br = 1; tx_wv = 0; @(posedge clk); #1; tx_br = 0;
    chk(tx_wr && !tx_bv, "R7 ready after hi", tx_wr, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin fails++; checks++; $display("FAIL watchdog"); $display("%0d/%0d checks passed", checks-fails, checks); $finish; end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk(tx_wr == 1 && tx_bv == 0 && rx_wv == 0, "R1 reset state", {tx_wr, tx_bv, rx_wv}, 3'b100);
    rst_ni = 1; @(posedge clk); #1;
    chk(tx_wr == 1 && tx_bv == 0 && rx_wv == 0, "R1 after reset", {tx_wr, tx_bv, rx_wv}, 3'b100);
    // R2 spaced pair
    rx_byte(8'h34); @(posedge clk); #1; rx_byte(8'h12);
    @(posedge clk); #1;
    chk(rx_wv == 0, "R3 single pulse", rx_wv, 0);
    // R4 back-to-back burst
    for (int i = 0; i < 9; i++) rx_byte(8'(8'hA0 + i));
    rx_byte(8'h55);
    // R5 resync with held low byte (idle resync)
    rx_byte(8'h77); resync = 1; @(posedge clk); #1; resync = 0; have_lo = 0;
    rx_byte(8'hCD); rx_byte(8'hAB);
    // R5 resync together with byte
    rx_byte(8'h11); rx_byte(8'h22, 1); rx_byte(8'h33);
    repeat (3) @(posedge clk); #1;
    chk(rx_exp.size() == 0, "R4 all rx words seen", rx_exp.size(), 0);
    // transmit
    tx_send(16'hBEEF, 0, 0);
    tx_send(16'h1234, 3, 0);
    tx_send(16'h5A6B, 0, 4);
    tx_send(16'hC0DE, 2, 2);
    repeat (3) @(posedge clk); #1;
    chk(tx_exp.size() == 0, "R6 all tx bytes seen", tx_exp.size(), 0);
    chk(!tx_bv, "R7 idle no byte", tx_bv, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end
endmodule